// File: doc/BRIEF.md
# Extended-Address Program Bank Mapper

This block sits on the cartridge side of an 8-bit CPU bus and turns CPU writes into bank settings. The CPU first writes a register index to an even address in $8000–$9FFF. It then writes a value to an odd address in the same range, and that value goes into the register the index picked. From the two program-bank registers and the banking mode, the block forms a 20-bit program-ROM address for each of the four 8 KB windows in $8000–$FFFF.

Bit 0 of bank register 0 is the special feature. It does not bank character memory. It becomes bit 6 of the program bank number in every window, so the reachable program space doubles to 128 banks of 8 KB.

The block also decodes chip selects for an 8 KB work RAM at $6000–$7FFF and for an 8 KB character RAM on the picture bus, which is never banked. A mirroring output tells the nametable logic whether to mirror horizontally or vertically. Scanline interrupt logic is not part of this block.

Top module: `xbm_mapper`

## Requirements
- R1: While `rst` is high and after its release, the bank select, register 0, register 6 and register 7 all read as zero and `mirror_h` is 0 (vertical). So $8000 maps to bank 0 and $C000 maps to bank 0x3E.
- R2: `prg_addr[12:0]` always equals `cpu_addr[12:0]`, and `prg_addr[19:13]` is the 7-bit bank number.
- R3: With `cpu_wr` high, an even address in $8000–$9FFF stores the data into bank select. Bits 2:0 of that data are the register index and bit 6 is the program mode. An odd address in $8000–$9FFF loads the data into the register that the index names. A write to index 1–5 leaves every program window unchanged.
- R4: In mode 0 the windows use these base banks: $8000 uses R6[5:0], $C000 uses 0x3E and $E000 uses 0x3F.
- R5: In mode 1 the $8000 and $C000 base banks trade places: $8000 uses 0x3E and $C000 uses R6[5:0]. $E000 stays at 0x3F.
- R6: $A000 always uses R7[5:0] as its base bank, in both modes. Bits 7:6 of R7 are ignored.
- R7: Bank bit 6 (`prg_addr[19]`) equals R0 bit 0 in all four windows, the fixed windows included. Bits 7:1 of R0 have no effect.
- R8: A write to an even address in $A000–$BFFF sets `mirror_h` to data bit 0 (1 = horizontal, 0 = vertical). A write to an odd address in $A000–$BFFF leaves `mirror_h` unchanged.
- R9: `wram_cs` is high exactly for $6000–$7FFF and `prg_cs` is high exactly for $8000–$FFFF.
- R10: `chr_cs` is high exactly when `ppu_addr[13]` is 0, and `chr_addr` equals `ppu_addr[12:0]` whatever R0 holds.
- R11: Writes to $C000–$FFFF and writes below $8000 change no bank register and do not change the mirroring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| ppu_addr | input | 14 | Picture-bus address |
| prg_addr | output | 20 | Program-ROM address (bank, offset) |
| prg_cs | output | 1 | Program-ROM select |
| wram_cs | output | 1 | Work RAM select |
| chr_cs | output | 1 | Character RAM select |
| chr_addr | output | 13 | Character RAM address |
| mirror_h | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The bench sweeps every R6 value against both modes and both values of the high bit. For each combination it checks all four windows with a different offset, computing the expected bank arithmetically. This catches a design that applies the high bit only to the switchable windows: the fixed $C000/$E000 banks would then stay below 64. It also catches a mode swap that disturbs $A000 or $E000.

Upper register bits are set on purpose, so a design that fails to mask R6/R7 to six bits, or that takes R0 bit 7 instead of bit 0, shows wrong banks. Writes to $C000–$FFFF, to work RAM, to odd $A000 addresses and to indices 1–5 are each followed by a readback of every window and of the mirroring output. Any stray decode that changes state therefore shows at the ports.

// File: rtl/xbm_pkg.sv
package xbm_pkg;

    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int BASE_W   = 6;
    localparam int OFS_W    = 13;
    localparam int BANK_W   = BASE_W + 1;
    localparam int PRG_AW   = BANK_W + OFS_W;
    localparam int PPU_AW   = 14;
    localparam int CHR_AW   = PPU_AW - 1;
    localparam int MODE_BIT = 6;

    localparam logic [IDX_W-1:0]  IDX_HIGH = IDX_W'(0);
    localparam logic [IDX_W-1:0]  IDX_LOW  = IDX_W'(6);
    localparam logic [IDX_W-1:0]  IDX_MID  = IDX_W'(7);
    localparam logic [BASE_W-1:0] LAST_BASE = {BASE_W{1'b1}};
    localparam logic [BASE_W-1:0] PENULT_BASE = LAST_BASE - BASE_W'(1);

    typedef enum logic [1:0] {
        WIN_8000 = 2'd0,
        WIN_A000 = 2'd1,
        WIN_C000 = 2'd2,
        WIN_E000 = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_SELECT,
        WR_DATA,
        WR_MIRROR
    } wr_kind_e;

    typedef struct packed {
        logic              prg_mode;
        logic [IDX_W-1:0]  idx;
    } sel_t;

    typedef struct packed {
        logic              hi;
        logic              mode;
        logic [BASE_W-1:0] low_bank;
        logic [BASE_W-1:0] mid_bank;
    } bank_view_t;

    function automatic wr_kind_e classify_write(input logic [CPU_AW-1:0] a);
        wr_kind_e k;
        k = WR_NONE;
        if (a[CPU_AW-1]) begin
            unique case (win_e'(a[OFS_W+1:OFS_W]))
                WIN_8000: k = a[0] ? WR_DATA : WR_SELECT;
                WIN_A000: k = a[0] ? WR_NONE : WR_MIRROR;
                default:  k = WR_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic logic [BASE_W-1:0] window_base(input win_e w, input bank_view_t v);
        logic [BASE_W-1:0] b;
        unique case (w)
            WIN_8000: b = v.mode ? PENULT_BASE : v.low_bank;
            WIN_A000: b = v.mid_bank;
            WIN_C000: b = v.mode ? v.low_bank : PENULT_BASE;
            default:  b = LAST_BASE;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/xbm_wr_decode.sv
module xbm_wr_decode
    import xbm_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    output wr_kind_e          kind
);
    always_comb begin
        kind = cpu_wr ? classify_write(cpu_addr) : WR_NONE;
    end
endmodule

// File: rtl/xbm_regfile.sv
module xbm_regfile
    import xbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] data,
    output bank_view_t        view,
    output logic              mirror_h
);
    sel_t              sel_q;
    logic              hi_q;
    logic [BASE_W-1:0] low_q;
    logic [BASE_W-1:0] mid_q;
    logic              mirror_q;

    logic unused_data_bits;
    assign unused_data_bits = ^{data[DATA_W-1], data[MODE_BIT-1:IDX_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            hi_q     <= 1'b0;
            low_q    <= '0;
            mid_q    <= '0;
            mirror_q <= 1'b0;
        end else begin
            unique case (kind)
                WR_SELECT: begin
                    sel_q.idx      <= data[IDX_W-1:0];
                    sel_q.prg_mode <= data[MODE_BIT];
                end
                WR_DATA: begin
                    if (sel_q.idx == IDX_HIGH) hi_q  <= data[0];
                    if (sel_q.idx == IDX_LOW)  low_q <= data[BASE_W-1:0];
                    if (sel_q.idx == IDX_MID)  mid_q <= data[BASE_W-1:0];
                end
                WR_MIRROR: mirror_q <= data[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        view.hi       = hi_q;
        view.mode     = sel_q.prg_mode;
        view.low_bank = low_q;
        view.mid_bank = mid_q;
    end
    assign mirror_h = mirror_q;
endmodule

// File: rtl/xbm_prg_map.sv
module xbm_prg_map
    import xbm_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  bank_view_t        view,
    output logic [PRG_AW-1:0] prg_addr
);
    win_e              win;
    logic [BASE_W-1:0] base;
    logic [BANK_W-1:0] bank;

    always_comb begin
        win      = win_e'(cpu_addr[OFS_W+1:OFS_W]);
        base     = window_base(win, view);
        bank     = {view.hi, base};
        prg_addr = {bank, cpu_addr[OFS_W-1:0]};
    end
endmodule

// File: rtl/xbm_mem_decode.sv
module xbm_mem_decode
    import xbm_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic              prg_cs,
    output logic              wram_cs,
    output logic              chr_cs,
    output logic [CHR_AW-1:0] chr_addr
);
    localparam logic [2:0] WRAM_PAGE = 3'b011;

    always_comb begin
        prg_cs   = cpu_addr[CPU_AW-1];
        wram_cs  = (cpu_addr[CPU_AW-1:OFS_W] == WRAM_PAGE);
        chr_cs   = ~ppu_addr[PPU_AW-1];
        chr_addr = ppu_addr[CHR_AW-1:0];
    end
endmodule

// File: rtl/xbm_mapper.sv
module xbm_mapper
    import xbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic [13:0]       ppu_addr,
    output logic [19:0]       prg_addr,
    output logic              prg_cs,
    output logic              wram_cs,
    output logic              chr_cs,
    output logic [12:0]       chr_addr,
    output logic              mirror_h
);
    wr_kind_e   kind;
    bank_view_t view;

    xbm_wr_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .kind     (kind)
    );

    xbm_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .data     (cpu_data),
        .view     (view),
        .mirror_h (mirror_h)
    );

    xbm_prg_map u_map (
        .cpu_addr (cpu_addr),
        .view     (view),
        .prg_addr (prg_addr)
    );

    xbm_mem_decode u_mem (
        .cpu_addr (cpu_addr),
        .ppu_addr (ppu_addr),
        .prg_cs   (prg_cs),
        .wram_cs  (wram_cs),
        .chr_cs   (chr_cs),
        .chr_addr (chr_addr)
    );
endmodule

// File: rtl/xbm_mapper_chk.sv
module xbm_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        cpu_wr,
    input logic [13:0] ppu_addr,
    input logic [19:0] prg_addr,
    input logic        prg_cs,
    input logic        wram_cs,
    input logic        chr_cs,
    input logic [12:0] chr_addr,
    input logic        mirror_h
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    logic unused_chk;
    assign unused_chk = ^cpu_data;

    // R2: offset bits pass straight through
    a_r2_offset: assert property (@(posedge clk) disable iff (rst)
        prg_addr[12:0] == cpu_addr[12:0]);

    // R4, R5: the last window is fixed at base 0x3F
    a_r4_last_fixed: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[15:13] == 3'b111 |-> prg_addr[18:13] == 6'h3F);

    // R8: mirroring moves only after an even $A000 write
    a_r8_mirror_source: assert property (@(posedge clk) disable iff (rst)
        seen && !$stable(mirror_h) |->
        $past(cpu_wr && cpu_addr[15:13] == 3'b101 && !cpu_addr[0]));

    // R9: work RAM and program ROM never selected together
    a_r9_cs_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wram_cs && prg_cs));

    // R10: character RAM address is the picture-bus address
    a_r10_chr_flat: assert property (@(posedge clk) disable iff (rst)
        chr_addr == ppu_addr[12:0] && chr_cs == !ppu_addr[13]);

    // R11: a write at $C000-$FFFF leaves the mapping unchanged
    a_r11_upper_ignored: assert property (@(posedge clk) disable iff (rst)
        seen && $past(cpu_wr && cpu_addr[15:14] == 2'b11) && $stable(cpu_addr)
        |-> $stable(prg_addr) && $stable(mirror_h));
endmodule

bind xbm_mapper xbm_mapper_chk u_chk (.*);

// File: tb/xbm_mapper_tb.sv
module xbm_mapper_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic [19:0] prg_addr;
    logic        prg_cs, wram_cs, chr_cs, mirror_h;
    logic [12:0] chr_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbm_mapper u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .prg_cs(prg_cs), .wram_cs(wram_cs), .chr_cs(chr_cs),
        .chr_addr(chr_addr), .mirror_h(mirror_h)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    function automatic int exp_bank(input int win, input int r6, input int r7,
                                    input int mode, input int hb);
        int b;
        case (win)
            0: b = mode ? 62 : (r6 & 63);
            1: b = r7 & 63;
            2: b = mode ? (r6 & 63) : 62;
            default: b = 63;
        endcase
        return hb * 64 + b;
    endfunction

    task automatic probe(input string req, input int win, input int ofs, input int bank);
        cpu_addr = 16'(32'h8000 + win * 32'h2000 + (ofs & 32'h1FFF));
        #1;
        check(req, int'(prg_addr), bank * 8192 + (ofs & 8191));
    endtask

    task automatic probe_all(input string req, input int r6, input int r7,
                             input int mode, input int hb);
        for (int w = 0; w < 4; w++)
            probe(req, w, 37 * w + r6 * 129, exp_bank(w, r6, r7, mode, hb));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: during reset
        probe("R1", 0, 5, 0);
        check("R1", int'(mirror_h), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: after release
        probe_all("R1", 0, 0, 0, 0);
        check("R1", int'(mirror_h), 0);

        // R2 with R3-R7: full sweep of R6, mode, high bit; R7 upper bits set
        for (int hb = 0; hb < 2; hb++) begin
            wr(16'h8000, 8'h00);
            wr(16'h8001, 8'(8'hFE | hb));
            wr(16'h8000, 8'h07);
            wr(16'h8001, 8'(8'hC0 | (hb ? 8'h15 : 8'h2A)));
            for (int mode = 0; mode < 2; mode++) begin
                for (int r6 = 0; r6 < 64; r6++) begin
                    wr(16'h8000, 8'(mode * 64 + 6));
                    wr(16'h9FFF, 8'(r6 | ((r6 & 1) ? 8'h80 : 8'h40)));
                    probe_all(mode ? "R5_R7" : "R4_R7", r6, hb ? 8'h15 : 8'h2A, mode, hb);
                end
            end
        end

        // R3: indices 1..5 leave every window alone (state R6=63,R7=0x15,mode1,hb1)
        for (int i = 1; i < 6; i++) begin
            wr(16'h8000, 8'(64 + i));
            wr(16'h8001, 8'h5A);
        end
        wr(16'h8000, 8'h46);
        probe_all("R3", 63, 8'h15, 1, 1);

        // R6: R7 in both modes, upper bits masked
        wr(16'h8000, 8'h47);
        wr(16'h8003, 8'hFF);
        probe("R6", 1, 100, 127);
        wr(16'h8000, 8'h07);
        probe("R6", 1, 200, 127);

        // R8: even $A000 sets, odd $A000 ignored
        wr(16'hA000, 8'h01);
        #1 check("R8", int'(mirror_h), 1);
        wr(16'hA001, 8'h00);
        #1 check("R8", int'(mirror_h), 1);
        wr(16'hBFFE, 8'hFE);
        #1 check("R8", int'(mirror_h), 0);

        // R11: upper and low-range writes ignored (state R6=63,R7=63,mode0,hb1)
        wr(16'hC000, 8'hFF);
        wr(16'hC001, 8'h41);
        wr(16'hE000, 8'h01);
        wr(16'hE001, 8'hFF);
        wr(16'h6000, 8'h40);
        wr(16'h7FFF, 8'h01);
        wr(16'h0000, 8'h41);
        wr(16'h4001, 8'h01);
        probe_all("R11", 63, 63, 0, 1);
        #1 check("R11", int'(mirror_h), 0);

        // R7: clear high bit, fixed windows drop below 64
        wr(16'h8000, 8'h00);
        wr(16'h8001, 8'hFE);
        probe_all("R7", 63, 63, 0, 0);

        // R9: chip selects over every 4 KB page
        for (int p = 0; p < 16; p++) begin
            cpu_addr = 16'(p * 4096 + 123);
            #1;
            check("R9", int'(wram_cs), (p == 6 || p == 7) ? 1 : 0);
            check("R9", int'(prg_cs), (p >= 8) ? 1 : 0);
        end

        // R10: character RAM flat with R0 both ways
        for (int hb = 0; hb < 2; hb++) begin
            wr(16'h8000, 8'h00);
            wr(16'h8001, 8'(hb));
            for (int a = 0; a < 16384; a += 1021) begin
                ppu_addr = 14'(a);
                #1;
                check("R10", int'(chr_cs), (a < 8192) ? 1 : 0);
                check("R10", int'(chr_addr), a & 8191);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule